// File: doc/BRIEF.md
# Serial Tuning-Word Receiver Register

This block is the receiving end of a three-wire, write-only serial port that sets the tuning state of a device. The host raises an enable line, presents one data bit per serial clock pulse, and drops the enable when it is done. All three lines are sampled by a much faster system clock. Each line passes through a two-stage synchronizer, and its edges are found from the synchronized copies.

While the enable is high, every rising serial-clock edge pushes the data bit into an 8-bit shift register. The receiver never counts bits, so the register always holds the most recent eight. When the enable falls, that byte is copied into an output holding register. The holding register drives three outputs: a 5-bit state code, a standby flag, and an error flag that is raised when either of the two reserved top bits was written as 1. A word with reserved bits set is still applied.

Several receivers can share the clock and data lines, each with its own enable line. Only the receiver whose enable is pulsed commits a new value.

Top module: `tune_word_rx`

## Requirements
- R1: After reset, the state code is 0, the standby flag is 0 and the error flag is 0. The shift register is also cleared, so an enable pulse with no clock pulses commits the byte 0x00.
- R2: A data bit is taken on each rising serial-clock edge while the enable is high. Bits enter at the least significant end, so the first of eight bits ends up in bit 7 (most significant bit first).
- R3: Serial-clock edges while the enable is low are ignored. The outputs do not change, and the shift-register contents are preserved for the next commit.
- R4: The outputs change only after a falling edge of the enable. While a transfer is in progress they keep the last committed value.
- R5: When more than eight bits arrive in one transfer, only the last eight are committed.
- R6: Committed byte layout: bits 4..0 drive the state code, and bit 5 drives the standby flag (0 = active, 1 = low-current standby).
- R7: The error flag is 1 when bit 7 or bit 6 of the committed byte is 1, and 0 otherwise. The state code and standby flag are still updated from that byte.
- R8: An enable pulse with no serial-clock edges recommits the current shift-register contents unchanged.
- R9: A transfer of fewer than eight bits commits the earlier contents shifted left by the number of new bits, with the new bits in the low positions.
- R10: When a rising serial-clock edge and the enable's falling edge are seen in the same system-clock cycle, that bit is included in the committed byte.
- R11: The outputs reflect a new commit within five system clocks of the enable pin falling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_en | input | 1 | Asynchronous transfer enable, active high |
| ser_clk | input | 1 | Asynchronous serial clock; data is taken on its rising edge |
| ser_dat | input | 1 | Asynchronous serial data, most significant bit first |
| state_code | output | 5 | Committed 5-bit tuning state |
| standby | output | 1 | Committed standby flag, 1 = low-current standby |
| rsv_err | output | 1 | 1 when the committed byte had a reserved bit set |

## Verification
Shifting and committing can occur in the same system-clock cycle. This happens when the last rising serial-clock edge and the falling enable are synchronized together. The bench provokes this by driving both pins in the same instant after seven bits. The scoreboard then expects a byte that contains the eighth bit. Separately, a checker property compares the state code with the forwarded shift value in exactly those cycles.

// File: rtl/tune_rx_pkg.sv
// Package: shared sizes and line indices for the serial tuning-word receiver.
// Assumes a word made of reserved bits, one standby bit and a state code.
package tune_rx_pkg;
    localparam int WORD_BITS  = 8;   // length of one transfer word
    localparam int CODE_BITS  = 5;   // width of the tuning state code
    localparam int SYNC_DEPTH = 2;   // synchronizer flip-flops per line
    localparam int NUM_LINES  = 3;   // enable, clock, data
    localparam int LINE_EN    = 0;
    localparam int LINE_CLK   = 1;
    localparam int LINE_DAT   = 2;
endpackage

// File: rtl/tune_line_sync.sv
// Module: tune_line_sync
// Brings NUM asynchronous lines into the clk domain through STAGES flops each.
// Adds one more flop per line so edges can be found from the synchronized copy.
// Assumes each input stays at a level for longer than STAGES+1 clk cycles.
module tune_line_sync #(
    parameter int NUM    = 3,
    parameter int STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] din,
    output logic [NUM-1:0] lvl,
    output logic [NUM-1:0] prev
);
    localparam int CHAIN = STAGES + 1;

    logic [NUM-1:0][CHAIN-1:0] pipe;

    for (genvar g = 0; g < NUM; g++) begin : g_line
        // Purpose: shift one line through its synchronizer and delay flop.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pipe[g] <= '0;
            end else begin
                pipe[g] <= {pipe[g][CHAIN-2:0], din[g]};
            end
        end
        assign lvl[g]  = pipe[g][STAGES-1];
        assign prev[g] = pipe[g][STAGES];
    end
endmodule

// File: rtl/tune_shift_capture.sv
// Module: tune_shift_capture
// Keeps the last W bits seen on rising serial-clock edges while the enable
// is (or was, one cycle earlier) high. No bit counter is kept.
// Offers the value after this cycle's shift so that a commit in the same
// cycle includes a coincident bit.
// Assumes synchronized, edge-detected inputs.
module tune_shift_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_lvl,
    input  logic         en_prev,
    input  logic         clk_rise,
    input  logic         dat,
    output logic [W-1:0] sh,
    output logic [W-1:0] sh_next
);
    logic take_bit;

    // Purpose: decide whether this cycle's clock edge belongs to a transfer.
    always_comb begin
        take_bit = clk_rise && (en_lvl || en_prev);
    end

    // Purpose: form the shift-register value after this cycle.
    always_comb begin
        sh_next = take_bit ? {sh[W-2:0], dat} : sh;
    end

    // Purpose: hold the shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh <= '0;
        end else begin
            sh <= sh_next;
        end
    end
endmodule

// File: rtl/tune_commit_reg.sv
// Module: tune_commit_reg
// Output holding register. It loads a word on a commit strobe and splits it
// into a state code, a standby flag and a reserved-bit error flag.
// Assumes a word layout of rsv | standby | code, with the code at the bottom.
module tune_commit_reg #(
    parameter int W      = 8,
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [W-1:0]      word,
    output logic [CODE_W-1:0] code,
    output logic              stby,
    output logic              err
);
    localparam int STBY_POS = CODE_W;
    localparam int RSV_LSB  = CODE_W + 1;

    // Purpose: load the decoded fields when a transfer ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code <= '0;
            stby <= 1'b0;
            err  <= 1'b0;
        end else if (commit) begin
            code <= word[CODE_W-1:0];
            stby <= word[STBY_POS];
            err  <= |word[W-1:RSV_LSB];
        end
    end
endmodule

// File: rtl/tune_word_rx.sv
// Module: tune_word_rx (top)
// Slave receiver for a three-wire write-only tuning port. It synchronizes
// the lines, shifts bits in while the enable is high, and commits the last
// WORD_W bits when the enable falls.
// Assumes the serial lines are much slower than clk.
module tune_word_rx
    import tune_rx_pkg::*;
#(
    parameter int WORD_W      = WORD_BITS,
    parameter int CODE_W      = CODE_BITS,
    parameter int SYNC_STAGES = SYNC_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_en,
    input  logic              ser_clk,
    input  logic              ser_dat,
    output logic [CODE_W-1:0] state_code,
    output logic              standby,
    output logic              rsv_err
);
    logic [NUM_LINES-1:0] raw_lines;
    logic [NUM_LINES-1:0] sync_lvl;
    logic [NUM_LINES-1:0] sync_prev;
    logic                 en_lvl;
    logic                 en_prev;
    logic                 sclk_rise;
    logic                 dat_lvl;
    logic                 en_fall;
    logic [WORD_W-1:0]    sh;
    logic [WORD_W-1:0]    sh_next;

    // Purpose: gather the pins in the package's line order.
    always_comb begin
        raw_lines           = '0;
        raw_lines[LINE_EN]  = ser_en;
        raw_lines[LINE_CLK] = ser_clk;
        raw_lines[LINE_DAT] = ser_dat;
    end

    tune_line_sync #(
        .NUM    (NUM_LINES),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_lines),
        .lvl   (sync_lvl),
        .prev  (sync_prev)
    );

    // Purpose: derive levels and edges from the synchronized lines.
    always_comb begin
        en_lvl    = sync_lvl[LINE_EN];
        en_prev   = sync_prev[LINE_EN];
        sclk_rise = sync_lvl[LINE_CLK] && !sync_prev[LINE_CLK];
        dat_lvl   = sync_lvl[LINE_DAT];
        en_fall   = en_prev && !en_lvl;
    end

    tune_shift_capture #(
        .W (WORD_W)
    ) shift_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_lvl   (en_lvl),
        .en_prev  (en_prev),
        .clk_rise (sclk_rise),
        .dat      (dat_lvl),
        .sh       (sh),
        .sh_next  (sh_next)
    );

    tune_commit_reg #(
        .W      (WORD_W),
        .CODE_W (CODE_W)
    ) commit_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (en_fall),
        .word   (sh_next),
        .code   (state_code),
        .stby   (standby),
        .err    (rsv_err)
    );
endmodule

// File: rtl/tune_word_rx_chk.sv
// Module: tune_word_rx_chk
// Property checker for tune_word_rx, attached with bind.
// Assumes the top's internal names en_lvl, en_prev, sclk_rise, dat_lvl and sh.
module tune_word_rx_chk #(
    parameter int WORD_W = 8,
    parameter int CODE_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_lvl,
    input logic              en_prev,
    input logic              sclk_rise,
    input logic              dat_lvl,
    input logic [WORD_W-1:0] sh,
    input logic [CODE_W-1:0] state_code,
    input logic              standby,
    input logic              rsv_err
);
    // R4: outputs move only in the cycle after an enable fall
    assert_out_only_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({rsv_err, standby, state_code}) |-> $past(en_prev && !en_lvl));

    // R6 / R7: a plain commit copies the shift register into the fields
    assert_commit_fields_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_prev && !en_lvl && !sclk_rise) |=>
        ({rsv_err, standby, state_code} ==
         {|$past(sh[WORD_W-1:CODE_W+1]), $past(sh[CODE_W:0])}));

    // R3: no shifting while the enable is low
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_lvl && !en_prev) |=> $stable(sh));

    // R2: a clock edge during a transfer shifts data in at the bottom
    assert_shift_msb_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_rise && en_lvl) |=>
        (sh == {$past(sh[WORD_W-2:0]), $past(dat_lvl)}));

    // R10: a coincident clock edge is part of the committed code
    assert_coincident_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (en_prev && !en_lvl && sclk_rise) |=>
        (state_code == {$past(sh[CODE_W-2:0]), $past(dat_lvl)}));
endmodule

bind tune_word_rx tune_word_rx_chk #(
    .WORD_W (WORD_W),
    .CODE_W (CODE_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_lvl     (en_lvl),
    .en_prev    (en_prev),
    .sclk_rise  (sclk_rise),
    .dat_lvl    (dat_lvl),
    .sh         (sh),
    .state_code (state_code),
    .standby    (standby),
    .rsv_err    (rsv_err)
);

// File: tb/tune_word_rx_tb_top.sv
// Scoreboard bench for tune_word_rx. Driver tasks model the shift register
// and queue expected bytes. A monitor pops one per enable fall and compares.
module tune_word_rx_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_en = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_dat = 1'b0;
    logic [4:0] state_code;
    logic       standby;
    logic       rsv_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [7:0] msh     = 8'h00;  // model shift register
    logic [7:0] exp_out = 8'h00;  // last byte expected committed
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;  // 125 MHz

    tune_word_rx dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_en     (ser_en),
        .ser_clk    (ser_clk),
        .ser_dat    (ser_dat),
        .state_code (state_code),
        .standby    (standby),
        .rsv_err    (rsv_err)
    );

    function automatic logic [6:0] fields(input logic [7:0] w);
        return {|w[7:6], w[5], w[4:0]};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [6:0] act, input logic [6:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got err/stby/code=%b expected %b", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_exp(input string tag);
        exp_q.push_back(msh);
        tag_q.push_back(tag);
        exp_out = msh;
    endtask

    // one serial bit: data settles, clock rises, clock falls
    task automatic put_bit(input logic b, input bit en_on);
        ser_dat = b;
        wait_cyc(3);
        ser_clk = 1'b1;
        if (en_on) msh = {msh[6:0], b};
        wait_cyc(3);
        ser_clk = 1'b0;
        wait_cyc(1);
    endtask

    // a full transfer of n bits from the low n of bits, top one first
    task automatic send_frame(input logic [31:0] bits, input int n, input string tag);
        ser_en = 1'b1;
        wait_cyc(4);
        for (int i = n - 1; i >= 0; i--) put_bit(bits[i], 1'b1);
        // R4: outputs still hold the previous commit mid-transfer
        chk(fields(exp_out) == {rsv_err, standby, state_code}, "R4 hold",
            {rsv_err, standby, state_code}, fields(exp_out));
        ser_en = 1'b0;
        push_exp(tag);
        wait_cyc(8);
    endtask

    // seven bits, then the eighth clock edge and enable fall together (R10)
    task automatic send_coincident(input logic [7:0] w);
        ser_en = 1'b1;
        wait_cyc(4);
        for (int i = 7; i >= 1; i--) put_bit(w[i], 1'b1);
        ser_dat = w[0];
        wait_cyc(3);
        ser_clk = 1'b1;
        ser_en  = 1'b0;
        msh = {msh[6:0], w[0]};
        push_exp("R10 coincident");
        wait_cyc(3);
        ser_clk = 1'b0;
        wait_cyc(8);
    endtask

    // monitor: one comparison per enable fall, five cycles later (R11)
    initial begin
        forever begin
            @(negedge ser_en);
            wait_cyc(5);
            if (exp_q.size() == 0) begin
                chk(1'b0, "monitor empty queue", {rsv_err, standby, state_code}, 7'h0);
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(fields(e) == {rsv_err, standby, state_code}, {t, " R11"},
                    {rsv_err, standby, state_code}, fields(e));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        wait_cyc(5);
        // R1: reset state
        chk({rsv_err, standby, state_code} == 7'h00, "R1 reset",
            {rsv_err, standby, state_code}, 7'h00);
        rst_n = 1'b1;
        wait_cyc(4);
        // R1 / R8: enable pulse without clocks commits cleared register (0x00)
        send_frame(32'h0, 0, "R1 cleared shift");
        // R2 / R6: active, code 0x16
        send_frame(32'h16, 8, "R2 R6 code");
        // R6: standby bit set, code 0x1F
        send_frame(32'h3F, 8, "R6 standby");
        // R7: reserved bit 7 set, code still applied
        send_frame(32'h85, 8, "R7 rsv7");
        // R7: reserved bit 6 set with standby
        send_frame(32'h61, 8, "R7 rsv6");
        // R7: clean word clears the flag
        send_frame(32'h03, 8, "R7 clear");
        // R5: eleven bits, last eight kept (0x09)
        send_frame(32'h709, 11, "R5 overlong");
        // R9: three bits shift earlier contents
        send_frame(32'h5, 3, "R9 short");
        // R3: clock activity with enable low is ignored
        for (int i = 0; i < 8; i++) put_bit(1'b1, 1'b0);
        chk(fields(exp_out) == {rsv_err, standby, state_code}, "R3 idle outputs",
            {rsv_err, standby, state_code}, fields(exp_out));
        // R3 / R8: enable pulse with no clocks recommits untouched contents
        send_frame(32'h0, 0, "R3 R8 recommit");
        // R10: coincident last bit and enable fall
        send_coincident(8'h2A);
        send_coincident(8'hD3);
        send_frame(32'h00, 8, "R6 zero");
        wait_cyc(10);
        done = 1'b1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule